// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer Mode

This block stores eight single-bit values that are written one at a time. A 3-bit index picks one of the eight storage bits, and a single data bit supplies the value. An active-low write enable and an active-high clear input together select one of four operating modes:

- **Indexed write**: the selected bit takes the data bit.
- **Hold**: nothing changes.
- **Demultiplex**: the selected bit takes the data bit and every other bit goes to zero.
- **Clear**: every bit goes to zero.

The block suits serial-to-parallel conversion, a small bank of control flags, or steering one data line to one of eight outputs. The latch behaviour is modelled as registers on a system clock. On each rising edge the block samples the mode pins, the index and the data bit, and the stored bits update on that same edge. The eight outputs show the stored bits.

A write that moves the index by more than one bit is unsafe on a level-sensitive part, so a status output warns about it. It flags, for one cycle, any pair of consecutive indexed-write samples whose indices differ in two or more bit positions.

Top module: `addr_latch8`

## Requirements
- R1: Output bit `q[i]` corresponds to index value `i` (`sel` = i). Every mode effect on a bit is visible on `q` right after the rising edge that sampled the inputs.
- R2: Indexed write mode is `wr_en_n`=0 and `clr`=0. In it, `q[sel]` becomes `din` and all other bits keep their values.
- R3: Hold mode is `wr_en_n`=1 and `clr`=0. In it, all eight bits keep their values whatever `sel` and `din` are.
- R4: Demultiplex mode is `wr_en_n`=0 and `clr`=1. In it, `q[sel]` becomes `din` and every other bit becomes 0, so at most one bit of `q` is 1.
- R5: Clear mode is `wr_en_n`=1 and `clr`=1. In it, all eight bits become 0.
- R6: The zeroing done by demultiplex and clear modes is stored. A following hold shows all zeros, except for a 1 written by demultiplex mode.
- R7: `skew_warn` is 1 for exactly the cycle after an edge when three conditions all hold: that edge sampled indexed write mode, the previous edge also sampled indexed write mode, and the two sampled indices differ in two or more bit positions. Otherwise `skew_warn` is 0.
- R8: A synchronous active-high `rst` sets all eight bits and `skew_warn` to 0. It also clears the index history, so the first write after reset never warns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write enable |
| clr | input | 1 | Active-high clear / demultiplex select |
| sel | input | 3 | Bit index |
| din | input | 1 | Data bit |
| q | output | 8 | Stored bits |
| skew_warn | output | 1 | One-cycle warning of a multi-bit index change during writes |

## Verification
The stored bits drive `q` directly, so any wrong stored bit appears at the ports one edge after the sample that caused it. A wrong bit also persists through later hold cycles until that bit is rewritten or cleared. The bench therefore compares all eight bits and the warning after every single cycle. This catches a bit written at the wrong index, a missed zeroing of the unselected bits, and a stale index history, each in the very cycle it first appears. Hold cycles after demultiplex and clear expose state that was stored but that the mode itself would have masked.

// File: rtl/alat_pkg.sv
package alat_pkg;

    parameter int SEL_W  = 3;
    localparam int NBITS = 1 << SEL_W;

    // Encoding is {clr, wr_en_n}
    typedef enum logic [1:0] {
        MODE_WRITE = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_DEMUX = 2'b10,
        MODE_CLEAR = 2'b11
    } mode_e;

    typedef struct packed {
        logic load_sel;     // selected bit takes din
        logic zero_others;  // unselected bits forced to 0
        logic zero_all;     // every bit forced to 0
    } ctrl_t;

    function automatic mode_e decode_mode(input logic en_n, input logic clr_i);
        return mode_e'({clr_i, en_n});
    endfunction

    function automatic ctrl_t mode_ctrl(input mode_e m);
        ctrl_t c;
        c = '0;
        unique case (m)
            MODE_WRITE: c.load_sel = 1'b1;
            MODE_HOLD:  c = '0;
            MODE_DEMUX: begin
                c.load_sel    = 1'b1;
                c.zero_others = 1'b1;
            end
            MODE_CLEAR: c.zero_all = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alat_mode_dec.sv
module alat_mode_dec
    import alat_pkg::*;
(
    input  logic  wr_en_n,
    input  logic  clr,
    output mode_e mode,
    output ctrl_t ctrl,
    output logic  is_write
);
    always_comb begin
        mode     = decode_mode(wr_en_n, clr);
        ctrl     = mode_ctrl(mode);
        is_write = (mode == MODE_WRITE);
    end
endmodule

// File: rtl/alat_store.sv
module alat_store
    import alat_pkg::*;
#(
    parameter int SW = 3,
    localparam int NB = 1 << SW
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  mode_e         mode,
    input  logic [SW-1:0] sel,
    input  logic          din,
    output logic [NB-1:0] q
);
    logic [NB-1:0] hit;

    for (genvar i = 0; i < NB; i++) begin : g_bit
        assign hit[i] = (sel == SW'(i));

        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (ctrl.zero_all)
                q[i] <= 1'b0;
            else if (hit[i] && ctrl.load_sel)
                q[i] <= din;
            else if (!hit[i] && ctrl.zero_others)
                q[i] <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q)); // R3

    AST_WRITE_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=>
        (((q ^ $past(q)) & ~(NB'(1) << $past(sel))) == '0)); // R2

    AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |=> $onehot0(q)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |=> (q == '0)); // R5
endmodule

// File: rtl/alat_skew_det.sv
module alat_skew_det #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_write,
    input  logic [SW-1:0] sel,
    output logic          warn
);
    logic [SW-1:0] prev_sel;
    logic          prev_wr;
    logic          multi_flip;

    always_comb multi_flip = ($countones(sel ^ prev_sel) > 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel <= '0;
            prev_wr  <= 1'b0;
            warn     <= 1'b0;
        end else begin
            prev_sel <= sel;
            prev_wr  <= is_write;
            warn     <= is_write && prev_wr && multi_flip;
        end
    end

    AST_WARN_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        warn |-> ($past(is_write) && $past(prev_wr))); // R7
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import alat_pkg::*;
#(
    parameter int SEL_BITS = alat_pkg::SEL_W,
    localparam int OUT_BITS = 1 << SEL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_n,
    input  logic                clr,
    input  logic [SEL_BITS-1:0] sel,
    input  logic                din,
    output logic [OUT_BITS-1:0] q,
    output logic                skew_warn
);
    mode_e mode;
    ctrl_t ctrl;
    logic  is_write;

    alat_mode_dec u_dec (
        .wr_en_n (wr_en_n),
        .clr     (clr),
        .mode    (mode),
        .ctrl    (ctrl),
        .is_write(is_write)
    );

    alat_store #(.SW(SEL_BITS)) u_store (
        .clk (clk),
        .rst (rst),
        .ctrl(ctrl),
        .mode(mode),
        .sel (sel),
        .din (din),
        .q   (q)
    );

    alat_skew_det #(.SW(SEL_BITS)) u_skew (
        .clk     (clk),
        .rst     (rst),
        .is_write(is_write),
        .sel     (sel),
        .warn    (skew_warn)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ((q == '0) && !skew_warn)); // R8
endmodule

// File: tb/addr_latch8_test.sv
`timescale 1ns/1ps
module addr_latch8_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en_n;
    logic       clr;
    logic [2:0] sel;
    logic       din;
    logic [7:0] q;
    logic       skew_warn;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    logic [7:0] exp_q;
    logic       exp_warn;
    logic [2:0] m_prev_sel;
    logic       m_prev_wr;

    always #5 clk = ~clk;

    addr_latch8 uut (
        .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .clr(clr),
        .sel(sel), .din(din), .q(q), .skew_warn(skew_warn)
    );

    function automatic int flips(input logic [2:0] a, input logic [2:0] b);
        int n = 0;
        for (int k = 0; k < 3; k++) if (a[k] != b[k]) n++;
        return n;
    endfunction

    task automatic chk(input string tag);
        tests++;
        if (q !== exp_q || skew_warn !== exp_warn) begin
            fails++;
            $display("FAIL %s: q=%h warn=%b expected q=%h warn=%b",
                     tag, q, skew_warn, exp_q, exp_warn);
        end
    endtask

    // Called at a falling edge: apply inputs, update model, check at next falling edge.
    task automatic cyc(input logic en_n, input logic c, input logic [2:0] s,
                       input logic d, input string tag);
        logic w;
        wr_en_n = en_n; clr = c; sel = s; din = d;
        w = !en_n && !c;
        exp_warn = w && m_prev_wr && (flips(s, m_prev_sel) > 1);
        case ({c, en_n})
            2'b00: exp_q[s] = d;
            2'b01: ;
            2'b10: begin exp_q = '0; exp_q[s] = d; end
            default: exp_q = '0;
        endcase
        m_prev_sel = s;
        m_prev_wr  = w;
        @(negedge clk);
        chk(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en_n = 1'b1; clr = 1'b0; sel = 3'd5; din = 1'b1;
        exp_q = '0; exp_warn = 1'b0; m_prev_sel = '0; m_prev_wr = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 reset state");
    endtask

    task automatic t_write_pattern();
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 3'(i), i[0] ^ i[2], "R1 R2 sequential write");
        for (int i = 7; i >= 0; i--) cyc(1'b0, 1'b0, 3'(i), ~exp_q[i], "R2 invert each bit");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 3'(i), ~exp_q[i], "R3 hold ignores sel/din");
    endtask

    task automatic t_demux();
        cyc(1'b0, 1'b0, 3'd2, 1'b1, "R2 prefill");
        cyc(1'b0, 1'b1, 3'd6, 1'b1, "R4 demux one");
        cyc(1'b0, 1'b1, 3'd1, 1'b1, "R4 demux moves");
        cyc(1'b1, 1'b0, 3'd4, 1'b1, "R6 hold after demux");
        cyc(1'b0, 1'b1, 3'd3, 1'b0, "R4 demux zero");
        cyc(1'b1, 1'b0, 3'd0, 1'b0, "R6 hold after demux zero");
    endtask

    task automatic t_clear();
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 3'(i), 1'b1, "R2 fill ones");
        cyc(1'b1, 1'b1, 3'd7, 1'b1, "R5 clear all");
        cyc(1'b1, 1'b0, 3'd7, 1'b1, "R6 hold after clear");
    endtask

    task automatic t_skew();
        cyc(1'b0, 1'b0, 3'd0, 1'b1, "R7 base");
        cyc(1'b0, 1'b0, 3'd3, 1'b0, "R7 two-bit change warns");
        cyc(1'b0, 1'b0, 3'd2, 1'b1, "R7 one-bit change quiet");
        cyc(1'b0, 1'b0, 3'd5, 1'b1, "R7 three-bit change warns");
        cyc(1'b1, 1'b0, 3'd5, 1'b0, "R7 hold quiet");
        cyc(1'b0, 1'b0, 3'd2, 1'b0, "R7 change via hold quiet");
        cyc(1'b0, 1'b1, 3'd5, 1'b0, "R7 demux no warn");
    endtask

    task automatic t_reset_mid();
        cyc(1'b0, 1'b0, 3'd0, 1'b1, "R2 before reset");
        do_reset();
        chk("R8 reset mid-run");
        cyc(1'b0, 1'b0, 3'd7, 1'b1, "R8 first write no warn");
    endtask

    task automatic t_random();
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[2] & r[3], r[6:4], r[7], "R1 random sequence");
        end
    endtask

    initial begin
        rst = 1'b1; wr_en_n = 1'b1; clr = 1'b0; sel = '0; din = 1'b0;
        exp_q = '0; exp_warn = 1'b0; m_prev_sel = '0; m_prev_wr = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_pattern();
        t_hold();
        t_demux();
        t_clear();
        t_skew();
        t_reset_mid();
        t_random();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule